// File: doc/BRIEF.md
# Memory-Operand T-State Sequencer

This block times the bus side of memory-operand instructions in an 8-bit processor core. Once an instruction has been decoded, the core presents an operation class, the current values of its address registers (HL, BC, SP and the index register IX), the two absolute-address operand bytes and the index displacement. It then raises `start` for one cycle. From that point the sequencer counts T-states. At fixed T-states it places an effective address on the bus together with a one-cycle read or write strobe. It collects the bytes it reads onto a result bus, updates the internal hidden-pointer value `memptr`, and pulses `done` on the instruction's last T-state. Opcode decoding, the arithmetic unit and the register file sit outside the block. For read-modify-write classes, the modified byte comes back from an external unit on `alu_result`.

T-state numbering is as follows. The clock edge that samples `start` while the block is idle begins the instruction. The cycle after that edge is T1, and each later cycle adds one. A strobe "at Tn" is high during cycle Tn. Read data on `mem_rdata` must be valid within that cycle, and it is captured at the edge that ends the cycle. All address arithmetic wraps modulo 65536.

The controller has five states. ST_IDLE is the reset state. ST_WAIT is a counted cycle with no bus activity. ST_READ and ST_WRITE drive one strobe each. ST_DONE is the final T-state. The transitions are:
- START: ST_IDLE to the state of T1, when `start` is high.
- ADVANCE: from any busy state to the state of the next T-state, chosen from the class schedule.
- FINISH: ST_DONE back to ST_IDLE.

Top module: `memop_sequencer`

## Requirements
- R1: After reset the block is idle: `mem_rd`, `mem_wr`, `done` are 0, and `mem_addr`, `mem_wdata`, `ld_data`, `memptr` are 0. A `start` sampled while idle begins an instruction whose T1 is the next cycle. Each strobe lasts one cycle. `mem_addr` and `mem_wdata` are 0 in every cycle without a strobe.
- R2: Class 0 (16-bit load from absolute address A = {`opnd_hi`,`opnd_lo`}) reads A at T10 and A+1 at T13, and ends at T16.
- R3: Class 1 (accumulator load from absolute address A) reads A at T10 and ends at T13.
- R4: Class 2 (stack-top exchange) reads SP at T4 and SP+1 at T7. It writes the old HL low byte to SP at T11 and the old HL high byte to SP+1 at T14, and ends at T19.
- R5: Class 3 (modify byte at HL) reads HL at T4, writes `alu_result` to HL at T8, and ends at T11.
- R6: Class 4 (load via HL) and class 5 (load via BC) read HL or BC respectively at T4 and end at T7.
- R7: Indexed classes use the address IX plus the displacement, with the displacement taken as a signed 8-bit two's-complement value (bit 7 set means negative).
- R8: Class 6 (indexed compare) reads at T12 and ends at T15. Class 7 (indexed modify) reads at T12, writes `alu_result` at T16, and ends at T19.
- R9: `done` is high for exactly one cycle, on the final T-state. The block is idle in the next cycle.
- R10: A `start` raised while the block is busy, including during the `done` cycle, is ignored.
- R11: In the cycle after `done`, `memptr` holds:
  - A+1 for classes 0 and 1;
  - BC+1 for class 5;
  - the 16-bit word read from the stack for class 2;
  - the indexed address for classes 6 and 7;
  - its previous value for classes 3 and 4.
- R12: `ld_data` is updated at the end of each read cycle. The first read loads {8'h00, byte}. The second read replaces bits 15:8 with the byte read.
- R13: The "+1" address of a second byte wraps: 16'hFFFF + 1 gives 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (ignored while busy) |
| op_class | input | 3 | Operation class 0..7 as listed in the requirements |
| reg_hl | input | 16 | HL value |
| reg_bc | input | 16 | BC value |
| reg_sp | input | 16 | Stack pointer value |
| reg_ix | input | 16 | Index register value |
| opnd_lo | input | 8 | Absolute-address low byte |
| opnd_hi | input | 8 | Absolute-address high byte |
| disp | input | 8 | Signed index displacement |
| alu_result | input | 8 | Modified byte for write-back |
| mem_rdata | input | 8 | Read data from memory |
| mem_addr | output | 16 | Bus address during a strobe, else 0 |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data during a write strobe, else 0 |
| ld_data | output | 16 | Bytes collected by the reads |
| memptr | output | 16 | Hidden pointer value |
| done | output | 1 | Final T-state pulse |

## Verification
A wrong T-state count or a wrong state in the controller shifts a strobe or `done` by at least one cycle. The per-cycle comparison against the reference schedule catches this in the very cycle the strobe was due. A corrupted base address or a wrong choice between the first and second byte appears on `mem_addr` at the first strobe. A wrong write-back selection appears on `mem_wdata` at the write T-state. Faults in the result or pointer registers show one cycle after `done`, where `ld_data` and `memptr` are compared.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int SEQ_TW = 5;

    typedef enum logic [2:0] {
        OPC_LD16_ABS = 3'd0,
        OPC_LDA_ABS  = 3'd1,
        OPC_EX_SP_HL = 3'd2,
        OPC_RMW_HL   = 3'd3,
        OPC_LD_HL    = 3'd4,
        OPC_LD_BC    = 3'd5,
        OPC_CP_IX    = 3'd6,
        OPC_RMW_IX   = 3'd7
    } op_class_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } seq_state_e;

    // T-state of each bus event; 0 means the event is absent
    typedef struct packed {
        logic [SEQ_TW-1:0] rd_a;
        logic [SEQ_TW-1:0] rd_b;
        logic [SEQ_TW-1:0] wr_a;
        logic [SEQ_TW-1:0] wr_b;
        logic [SEQ_TW-1:0] last;
    } sched_t;

    function automatic seq_state_e state_of(input logic [SEQ_TW-1:0] t, input sched_t s);
        if (t == s.last)                      return ST_DONE;
        else if (t == s.rd_a || t == s.rd_b)  return ST_READ;
        else if (t == s.wr_a || t == s.wr_b)  return ST_WRITE;
        else                                  return ST_WAIT;
    endfunction
endpackage

// File: rtl/seq_sched.sv
module seq_sched
    import seq_pkg::*;
(
    input  op_class_e cls,
    output sched_t    sch
);
    always_comb begin
        sch = '0;
        unique case (cls)
            OPC_LD16_ABS: begin sch.rd_a = 5'd10; sch.rd_b = 5'd13; sch.last = 5'd16; end
            OPC_LDA_ABS:  begin sch.rd_a = 5'd10; sch.last = 5'd13; end
            OPC_EX_SP_HL: begin
                sch.rd_a = 5'd4;  sch.rd_b = 5'd7;
                sch.wr_a = 5'd11; sch.wr_b = 5'd14; sch.last = 5'd19;
            end
            OPC_RMW_HL:   begin sch.rd_a = 5'd4; sch.wr_a = 5'd8; sch.last = 5'd11; end
            OPC_LD_HL,
            OPC_LD_BC:    begin sch.rd_a = 5'd4; sch.last = 5'd7; end
            OPC_CP_IX:    begin sch.rd_a = 5'd12; sch.last = 5'd15; end
            OPC_RMW_IX:   begin sch.rd_a = 5'd12; sch.wr_a = 5'd16; sch.last = 5'd19; end
        endcase
    end
endmodule

// File: rtl/seq_addr.sv
module seq_addr
    import seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  op_class_e        cls,
    input  logic [AW-1:0]    hl,
    input  logic [AW-1:0]    bc,
    input  logic [AW-1:0]    sp,
    input  logic [AW-1:0]    ix,
    input  logic [AW-1:0]    abs_addr,
    input  logic [DW-1:0]    disp,
    output logic [AW-1:0]    base
);
    localparam int EXT_W = AW - DW;
    logic [AW-1:0] disp_sx;

    assign disp_sx = {{EXT_W{disp[DW-1]}}, disp};

    always_comb begin
        unique case (cls)
            OPC_LD16_ABS, OPC_LDA_ABS: base = abs_addr;
            OPC_EX_SP_HL:              base = sp;
            OPC_RMW_HL, OPC_LD_HL:     base = hl;
            OPC_LD_BC:                 base = bc;
            OPC_CP_IX, OPC_RMW_IX:     base = ix + disp_sx;
        endcase
    end
endmodule

// File: rtl/memop_sequencer.sv
module memop_sequencer
    import seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op_class,
    input  logic [AW-1:0] reg_hl,
    input  logic [AW-1:0] reg_bc,
    input  logic [AW-1:0] reg_sp,
    input  logic [AW-1:0] reg_ix,
    input  logic [DW-1:0] opnd_lo,
    input  logic [DW-1:0] opnd_hi,
    input  logic [DW-1:0] disp,
    input  logic [DW-1:0] alu_result,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic [AW-1:0] ld_data,
    output logic [AW-1:0] memptr,
    output logic          done
);
    localparam int TW = SEQ_TW;
    localparam logic [AW-1:0] ONE = AW'(1);

    seq_state_e    st, st_nx;
    logic [TW-1:0] tcnt, tcnt_nx;
    op_class_e     cls_q, cls_sel;
    logic [AW-1:0] base_q, base_in, hl_q;
    logic [AW-1:0] ld_q, mp_q;
    sched_t        sch;
    logic          hi_sel;
    logic          busy;

    assign busy    = (st != ST_IDLE);
    assign cls_sel = busy ? cls_q : op_class_e'(op_class);

    seq_sched u_sched (
        .cls (cls_sel),
        .sch (sch)
    );

    seq_addr #(.AW(AW), .DW(DW)) u_addr (
        .cls      (op_class_e'(op_class)),
        .hl       (reg_hl),
        .bc       (reg_bc),
        .sp       (reg_sp),
        .ix       (reg_ix),
        .abs_addr ({opnd_hi, opnd_lo}),
        .disp     (disp),
        .base     (base_in)
    );

    // next-state logic
    always_comb begin
        unique case (st)
            ST_IDLE: tcnt_nx = start ? TW'(1) : '0;
            ST_DONE: tcnt_nx = '0;
            default: tcnt_nx = tcnt + TW'(1);
        endcase
        st_nx = (tcnt_nx == '0) ? ST_IDLE : state_of(tcnt_nx, sch);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            tcnt <= '0;
        end else begin
            st   <= st_nx;
            tcnt <= tcnt_nx;
        end
    end

    // outputs
    always_comb begin
        hi_sel    = (tcnt == sch.rd_b) || (tcnt == sch.wr_b);
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        done      = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (st)
            ST_READ: begin
                mem_rd   = 1'b1;
                mem_addr = base_q + (hi_sel ? ONE : '0);
            end
            ST_WRITE: begin
                mem_wr   = 1'b1;
                mem_addr = base_q + (hi_sel ? ONE : '0);
                if (cls_q == OPC_EX_SP_HL)
                    mem_wdata = hi_sel ? hl_q[AW-1:DW] : hl_q[DW-1:0];
                else
                    mem_wdata = alu_result;
            end
            ST_DONE: done = 1'b1;
            ST_IDLE, ST_WAIT: ;
        endcase
    end

    // operand latches, result collection and hidden pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q  <= OPC_LD16_ABS;
            base_q <= '0;
            hl_q   <= '0;
            ld_q   <= '0;
            mp_q   <= '0;
        end else begin
            if (st == ST_IDLE && start) begin
                cls_q  <= op_class_e'(op_class);
                base_q <= base_in;
                hl_q   <= reg_hl;
            end
            if (st == ST_READ) begin
                if (hi_sel) ld_q[AW-1:DW] <= mem_rdata;
                else        ld_q <= {{(AW-DW){1'b0}}, mem_rdata};
            end
            if (st == ST_DONE) begin
                unique case (cls_q)
                    OPC_LD16_ABS, OPC_LDA_ABS, OPC_LD_BC: mp_q <= base_q + ONE;
                    OPC_EX_SP_HL:                        mp_q <= ld_q;
                    OPC_CP_IX, OPC_RMW_IX:               mp_q <= base_q;
                    OPC_RMW_HL, OPC_LD_HL:               mp_q <= mp_q;
                endcase
            end
        end
    end

    assign ld_data = ld_q;
    assign memptr  = mp_q;
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic          done
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr && !done)); // R1
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy); // R1
    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd); // R1
    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R9
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R10
    AST_NO_STROBE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr) && !(done && (mem_rd || mem_wr))); // R9
endmodule

bind memop_sequencer seq_checker #(.AW(AW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .done     (done)
);

// File: tb/test_memop_sequencer.sv
module test_memop_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_class = '0;
    logic [15:0] reg_hl = '0, reg_bc = '0, reg_sp = '0, reg_ix = '0;
    logic [7:0]  opnd_lo = '0, opnd_hi = '0, disp = '0;
    logic [7:0]  alu_result = '0, mem_rdata = '0;
    logic [15:0] mem_addr, ld_data, memptr;
    logic        mem_rd, mem_wr, done;
    logic [7:0]  mem_wdata;

    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    memop_sequencer i_memop_sequencer (.*);

    // behavioural reference state
    logic [7:0]  mem [int];
    int          act = 0, t = 0, rd1, rd2, wr1, wr2, lst;
    int          ccls;
    logic [15:0] base, hl_l, ld_exp = '0, mp_exp = '0;
    string       stag, atag, idle_tag = "R1", wrap_tag = "";

    function automatic logic [7:0] byte_at(int a);
        if (mem.exists(a)) return mem[a];
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h (t=%0d)", tag, what, got, exp, t);
        end
    endtask

    task automatic load_ref();
        logic [15:0] sx;
        ccls = int'(op_class);
        rd1 = 0; rd2 = 0; wr1 = 0; wr2 = 0;
        sx = {{8{disp[7]}}, disp};
        case (ccls)
            0: begin rd1 = 10; rd2 = 13; lst = 16; base = {opnd_hi, opnd_lo}; stag = "R2"; end
            1: begin rd1 = 10; lst = 13; base = {opnd_hi, opnd_lo}; stag = "R3"; end
            2: begin rd1 = 4; rd2 = 7; wr1 = 11; wr2 = 14; lst = 19; base = reg_sp; stag = "R4"; end
            3: begin rd1 = 4; wr1 = 8; lst = 11; base = reg_hl; stag = "R5"; end
            4: begin rd1 = 4; lst = 7; base = reg_hl; stag = "R6"; end
            5: begin rd1 = 4; lst = 7; base = reg_bc; stag = "R6"; end
            6: begin rd1 = 12; lst = 15; base = reg_ix + sx; stag = "R8"; end
            default: begin rd1 = 12; wr1 = 16; lst = 19; base = reg_ix + sx; stag = "R8"; end
        endcase
        atag = (ccls >= 6) ? "R7" : (wrap_tag != "") ? wrap_tag : stag;
        hl_l = reg_hl;
    endtask

    task automatic step();
        int was;
        bit erd, ewr, hi, edn;
        logic [15:0] eaddr;
        logic [7:0]  ewd, b;
        string tg;
        @(negedge clk);
        was = act;
        if (act != 0) begin
            if (t == lst) begin
                act = 0;
                case (ccls)
                    0, 1, 5: mp_exp = base + 16'd1;
                    2:       mp_exp = ld_exp;
                    6, 7:    mp_exp = base;
                    default: mp_exp = mp_exp;
                endcase
                chk(memptr == mp_exp, "R11", "memptr", memptr, mp_exp);
                chk(ld_data == ld_exp, "R12", "ld_data", ld_data, ld_exp);
            end else t++;
        end
        if (was == 0 && start && rst_n) begin
            act = 1; t = 1; load_ref();
        end
        start = 1'b0;
        erd = (act != 0) && (t == rd1 || t == rd2);
        ewr = (act != 0) && (t == wr1 || t == wr2);
        hi  = (t == rd2) || (t == wr2);
        edn = (act != 0) && (t == lst);
        eaddr = (erd || ewr) ? base + (hi ? 16'd1 : 16'd0) : 16'd0;
        ewd = 8'h00;
        if (ewr) ewd = (ccls == 2) ? (hi ? hl_l[15:8] : hl_l[7:0]) : ld_exp[7:0] - 8'd1;
        tg = (act != 0) ? stag : idle_tag;
        chk(mem_rd == erd, tg, "mem_rd", 16'(mem_rd), 16'(erd));
        chk(mem_wr == ewr, tg, "mem_wr", 16'(mem_wr), 16'(ewr));
        chk(mem_addr == eaddr, (act != 0) ? atag : idle_tag, "mem_addr", mem_addr, eaddr);
        chk(mem_wdata == ewd, tg, "mem_wdata", 16'(mem_wdata), 16'(ewd));
        chk(done == edn, (act != 0) ? "R9" : idle_tag, "done", 16'(done), 16'(edn));
        if (erd) begin
            b = byte_at(int'(eaddr));
            mem_rdata = b;
            ld_exp = hi ? {b, ld_exp[7:0]} : {8'h00, b};
        end else mem_rdata = 8'h00;
        if (ewr) mem[int'(eaddr)] = ewd;
        alu_result = ld_exp[7:0] - 8'd1;
    endtask

    task automatic go(input int c, input logic [15:0] hl, bc, sp, ix,
                      input logic [15:0] absa, input logic [7:0] d);
        op_class = 3'(c); reg_hl = hl; reg_bc = bc; reg_sp = sp; reg_ix = ix;
        {opnd_hi, opnd_lo} = absa; disp = d;
        start = 1'b1;
        step();
        while (act != 0) step();
        step(); step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(ld_data == 16'h0 && memptr == 16'h0 && !done && !mem_rd && !mem_wr,
            "R1", "reset state", {ld_data[7:0], memptr[7:0]}, 16'h0);

        go(0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h1234, 8'h00);  // R2
        wrap_tag = "R13";
        go(0, 16'h0, 16'h0, 16'h0, 16'h0, 16'hFFFF, 8'h00);  // R13 wrap
        wrap_tag = "";
        go(1, 16'h0, 16'h0, 16'h0, 16'h0, 16'h8000, 8'h00);  // R3
        go(2, 16'hBEEF, 16'h0, 16'h4000, 16'h0, 16'h0, 8'h00); // R4
        go(4, 16'h4000, 16'h0, 16'h0, 16'h0, 16'h0, 8'h00);  // R6 reads back R4 write
        wrap_tag = "R13";
        go(2, 16'hA55A, 16'h0, 16'hFFFF, 16'h0, 16'h0, 8'h00); // R13 stack wrap
        wrap_tag = "";
        go(3, 16'h2000, 16'h0, 16'h0, 16'h0, 16'h0, 8'h00);  // R5
        go(4, 16'h2000, 16'h0, 16'h0, 16'h0, 16'h0, 8'h00);  // R6 sees decremented byte
        go(5, 16'h0, 16'h3003, 16'h0, 16'h0, 16'h0, 8'h00);  // R6 via BC
        go(6, 16'h0, 16'h0, 16'h0, 16'h1000, 16'h0, 8'h80);  // R7 most negative
        go(6, 16'h0, 16'h0, 16'h0, 16'h1000, 16'h0, 8'h7F);  // R7 most positive
        go(7, 16'h0, 16'h0, 16'h0, 16'h0005, 16'h0, 8'hF0);  // R8 wraps below zero

        // R10: starts during busy and during the done cycle are ignored
        op_class = 3'd7; reg_ix = 16'h0200; disp = 8'h10;
        start = 1'b1;
        step();
        while (act != 0) begin
            if (t == 5 || t == lst) begin
                op_class = 3'd4; reg_hl = 16'h7777; start = 1'b1;
            end
            step();
        end
        idle_tag = "R10";
        repeat (6) step();
        idle_tag = "R1";
        chk(memptr == 16'h0210, "R10", "memptr after ignored starts", memptr, 16'h0210);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule